// File: doc/BRIEF.md
# Snoop Responder for One MOESI Line with Atomic-Touch Tracking

This block is the forwarded-request side of a broadcast-snoop L1 controller that keeps MOESI state plus transient and writeback-pending states for a single cache line. Each cycle a remote read (GETS) or remote write (GETX) may arrive. The block picks one answer from plain ack, shared ack, shared data, exclusive data, or data from the writeback record. It also computes the line's next state. When the line is in a transient state it stalls the request instead.

The line carries a dirty bit and an atomic-touched bit. Local write hits set the dirty bit. Local atomic hits also set the atomic-touched bit. Normally, a remote read of a migratory-modified line (MM) hands exclusive ownership to the requester. With the no-migration enable on, a line that an atomic has touched is instead answered with shared data and kept as owner (O). A locked line therefore keeps its write permission across plain remote reads. The rest of the controller moves the line through fills, transients and writebacks through a state-load port.

Top module: `snoop_resp_top`

## Requirements
- R1: A forwarded read is a no-migrate read (`rd_nomig`=1) only when `tag_hit`, `line_atomic` and `no_mig_en` are all 1. Otherwise it is an ordinary read. A forwarded write is never a no-migrate read.
- R2: A local write (`lcl_wr_valid`) in state M (3) or MM (4) sets `line_dirty` and moves the line to MM on the next edge. If `lcl_wr_atomic` is 1 it also sets `line_atomic`.
- R3: A local write has no effect in any other state, or in a cycle with `fwd_valid` or `set_valid` high.
- R4: In MM (4), a no-migrate read gives shared data (resp 3) and next state O (2). An ordinary read or a write gives exclusive data (resp 4) and next state I (0).
- R5: In M (3), either read flavour gives shared data (3) and next state O (2). A write gives exclusive data (4) and next state I (0).
- R6: Either read flavour gives a shared ack (2) in S (1) and SM (6), and shared data (3) in O (2) and OM (7). The state is unchanged in all four.
- R7: A write gives a plain ack (1) in S→I and SM→IM (5). It gives exclusive data (4) in O→I and OM→IM.
- R8: In I (0), IM (5), IS (8) and II (9), every forwarded request gets a plain ack (1) and the state does not change.
- R9: In IT (12), ST (13), OT (14), MT (15) and MMT (16), `fwd_ready` is 0, no response is given (resp 0), and the state is held.
- R10: In OI (10) and MI (11), a read gives data from the writeback record as shared (5) and next state OI. A write gives it as exclusive (6) and next state II (9).
- R11: `line_atomic` and `line_dirty` are cleared by a state load with `set_fresh`=1, by a state load to I, and by any accepted write request. A state load with `set_fresh`=0 to another state keeps them.
- R12: After reset the state is I (0), both bits are 0, and `resp_valid` is 0.
- R13: `set_valid` loads `set_state` on the next edge. In that cycle it forces `fwd_ready` to 0, so the forwarded request gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_is_write | input | 1 | 1 = remote write (GETX), 0 = remote read (GETS) |
| tag_hit | input | 1 | Line tag present for the request address |
| no_mig_en | input | 1 | Enable no-migration for atomic-touched lines |
| lcl_wr_valid | input | 1 | Local write hit |
| lcl_wr_atomic | input | 1 | Local write is atomic |
| set_valid | input | 1 | Controller loads a new state |
| set_state | input | 5 | State code to load |
| set_fresh | input | 1 | Load is a new allocation (clears bits) |
| fwd_ready | output | 1 | Forwarded request can be accepted this cycle |
| resp_valid | output | 1 | Response issued this cycle |
| resp_kind | output | 3 | Response code (0 none, 1 ack, 2 shared ack, 3 shared data, 4 exclusive data, 5 record data shared, 6 record data exclusive) |
| rd_nomig | output | 1 | Current request classified as no-migrate read |
| state_q | output | 5 | Current line state code |
| line_dirty | output | 1 | Line dirty bit |
| line_atomic | output | 1 | Line atomic-touched bit |

## Verification
On every cycle, the assertions check these behaviours:
- the classification conditions for no-migrate reads;
- the downgrade of MM to O on a no-migrate read;
- the stall in transient states;
- plain acks with the state held in invalid-class states;
- the bit clears on writes;
- that the atomic bit can rise only from an atomic local write.

The full response table across every state and both read flavours is covered only by the bench's scenarios. So are the side-by-side difference between the two read flavours in MM, and the effect of a fresh fill on a previously atomic-touched line. The same holds for a local write being ignored when it collides with a state load.

// File: rtl/snoop_resp_pkg.sv
// Package: shared line-state and response encodings for the snoop responder.
// Assumes: state codes fit in STW bits; response codes fit in RKW bits.
package snoop_resp_pkg;
    localparam int STW = 5;
    localparam int RKW = 3;

    typedef enum logic [STW-1:0] {
        LS_I   = 5'd0,  LS_S   = 5'd1,  LS_O   = 5'd2,  LS_M   = 5'd3,
        LS_MM  = 5'd4,  LS_IM  = 5'd5,  LS_SM  = 5'd6,  LS_OM  = 5'd7,
        LS_IS  = 5'd8,  LS_II  = 5'd9,  LS_OI  = 5'd10, LS_MI  = 5'd11,
        LS_IT  = 5'd12, LS_ST  = 5'd13, LS_OT  = 5'd14, LS_MT  = 5'd15,
        LS_MMT = 5'd16
    } lstate_t;

    typedef enum logic [RKW-1:0] {
        RK_NONE   = 3'd0, RK_ACK    = 3'd1, RK_ACK_SH = 3'd2,
        RK_DAT_SH = 3'd3, RK_DAT_EX = 3'd4, RK_WB_SH  = 3'd5,
        RK_WB_EX  = 3'd6
    } rkind_t;

    // True for the states that must stall forwarded requests.
    function automatic logic is_transient(lstate_t s);
        return (s == LS_IT) || (s == LS_ST) || (s == LS_OT) ||
               (s == LS_MT) || (s == LS_MMT);
    endfunction
endpackage

// File: rtl/snoop_classify.sv
// Module: snoop_classify
// Splits a forwarded request into write, ordinary read or no-migrate read.
// Assumes: line_atomic reflects the line's stored atomic-touched bit.
module snoop_classify (
    input  logic fwd_valid,
    input  logic fwd_is_write,
    input  logic tag_hit,
    input  logic line_atomic,
    input  logic no_mig_en,
    output logic is_getx,
    output logic is_gets,
    output logic is_nomig
);
    // Decode request flavour from request type and line metadata.
    always_comb begin
        is_getx  = fwd_valid && fwd_is_write;
        is_nomig = fwd_valid && !fwd_is_write && tag_hit && line_atomic && no_mig_en;
        is_gets  = fwd_valid && !fwd_is_write && !is_nomig;
    end
endmodule

// File: rtl/snoop_decide.sv
// Module: snoop_decide
// Pure decode of response kind and next state from current state and
// request flavour. Assumes at most one of the flavour inputs is high.
module snoop_decide
    import snoop_resp_pkg::*;
(
    input  lstate_t st,
    input  logic    is_getx,
    input  logic    is_gets,
    input  logic    is_nomig,
    output logic    stall,
    output rkind_t  kind,
    output lstate_t nxt
);
    logic any_rd;
    assign any_rd = is_gets || is_nomig;

    // Response table: one arm per state group.
    always_comb begin
        stall = 1'b0;
        kind  = RK_NONE;
        nxt   = st;
        if (is_transient(st)) begin
            stall = 1'b1;
        end else if (any_rd || is_getx) begin
            case (st)
                LS_S, LS_SM: begin
                    kind = is_getx ? RK_ACK : RK_ACK_SH;
                    if (is_getx) nxt = (st == LS_S) ? LS_I : LS_IM;
                end
                LS_O, LS_OM: begin
                    kind = is_getx ? RK_DAT_EX : RK_DAT_SH;
                    if (is_getx) nxt = (st == LS_O) ? LS_I : LS_IM;
                end
                LS_M: begin
                    kind = is_getx ? RK_DAT_EX : RK_DAT_SH;
                    nxt  = is_getx ? LS_I : LS_O;
                end
                LS_MM: begin
                    kind = is_nomig ? RK_DAT_SH : RK_DAT_EX;
                    nxt  = is_nomig ? LS_O : LS_I;
                end
                LS_OI, LS_MI: begin
                    kind = is_getx ? RK_WB_EX : RK_WB_SH;
                    nxt  = is_getx ? LS_II : LS_OI;
                end
                default: begin
                    kind = RK_ACK;
                end
            endcase
        end
    end
endmodule

// File: rtl/line_meta.sv
// Module: line_meta
// Holds the dirty and atomic-touched bits of the line.
// Assumes clr and set_dirty never coincide (caller gates them apart).
module line_meta (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_dirty,
    input  logic set_atomic,
    output logic dirty,
    output logic atomic
);
    // Update bits: clear wins, otherwise sticky set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dirty  <= 1'b0;
            atomic <= 1'b0;
        end else begin
            if (set_dirty)  dirty  <= 1'b1;
            if (set_atomic) atomic <= 1'b1;
        end
    end
endmodule

// File: rtl/snoop_resp_top.sv
// Module: snoop_resp_top
// Forwarded-request responder for one cache line. Holds line state,
// accepts state loads from the surrounding controller, applies local
// write hits and answers remote reads/writes. Responses are combinational
// in the request cycle; state and bits update on the next edge.
module snoop_resp_top
    import snoop_resp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fwd_valid,
    input  logic           fwd_is_write,
    input  logic           tag_hit,
    input  logic           no_mig_en,
    input  logic           lcl_wr_valid,
    input  logic           lcl_wr_atomic,
    input  logic           set_valid,
    input  logic [STW-1:0] set_state,
    input  logic           set_fresh,
    output logic           fwd_ready,
    output logic           resp_valid,
    output logic [RKW-1:0] resp_kind,
    output logic           rd_nomig,
    output logic [STW-1:0] state_q,
    output logic           line_dirty,
    output logic           line_atomic
);
    lstate_t st_r, st_dec, st_nxt;
    rkind_t  kind_dec;
    logic    c_getx, c_gets, c_nomig, dec_stall;
    logic    accept, lcl_take, meta_clr;

    snoop_classify u_cls (
        .fwd_valid    (fwd_valid),
        .fwd_is_write (fwd_is_write),
        .tag_hit      (tag_hit),
        .line_atomic  (line_atomic),
        .no_mig_en    (no_mig_en),
        .is_getx      (c_getx),
        .is_gets      (c_gets),
        .is_nomig     (c_nomig)
    );

    snoop_decide u_dec (
        .st       (st_r),
        .is_getx  (c_getx),
        .is_gets  (c_gets),
        .is_nomig (c_nomig),
        .stall    (dec_stall),
        .kind     (kind_dec),
        .nxt      (st_dec)
    );

    // Handshake and local-write qualification.
    always_comb begin
        fwd_ready = !set_valid && !is_transient(st_r);
        accept    = fwd_valid && fwd_ready && !dec_stall;
        lcl_take  = lcl_wr_valid && !fwd_valid && !set_valid &&
                    ((st_r == LS_M) || (st_r == LS_MM));
        meta_clr  = (set_valid && (set_fresh || (lstate_t'(set_state) == LS_I))) ||
                    (accept && c_getx);
    end

    // Next-state select: state load, then accepted request, then local write.
    always_comb begin
        if (set_valid)     st_nxt = lstate_t'(set_state);
        else if (accept)   st_nxt = st_dec;
        else if (lcl_take) st_nxt = LS_MM;
        else               st_nxt = st_r;
    end

    // Line state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_r <= LS_I;
        else        st_r <= st_nxt;
    end

    line_meta u_meta (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (meta_clr),
        .set_dirty  (lcl_take),
        .set_atomic (lcl_take && lcl_wr_atomic),
        .dirty      (line_dirty),
        .atomic     (line_atomic)
    );

    assign resp_valid = accept;
    assign resp_kind  = accept ? kind_dec : RK_NONE;
    assign rd_nomig   = c_nomig;
    assign state_q    = st_r;
endmodule

// File: rtl/snoop_resp_chk.sv
// Module: snoop_resp_chk
// Property checker for snoop_resp_top, attached by bind below.
module snoop_resp_chk
    import snoop_resp_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           fwd_valid,
    input logic           fwd_is_write,
    input logic           tag_hit,
    input logic           no_mig_en,
    input logic           lcl_wr_valid,
    input logic           lcl_wr_atomic,
    input logic           set_valid,
    input logic           fwd_ready,
    input logic           resp_valid,
    input logic [RKW-1:0] resp_kind,
    input logic           rd_nomig,
    input logic [STW-1:0] state_q,
    input logic           line_dirty,
    input logic           line_atomic
);
    logic idle_cls, trans_cls;
    assign idle_cls  = (state_q == LS_I) || (state_q == LS_IM) ||
                       (state_q == LS_IS) || (state_q == LS_II);
    assign trans_cls = (state_q >= LS_IT) && (state_q <= LS_MMT);

    p_nomig_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_nomig |-> (tag_hit && line_atomic && no_mig_en && fwd_valid && !fwd_is_write));

    p_lcl_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_wr_valid && !fwd_valid && !set_valid &&
         ((state_q == LS_M) || (state_q == LS_MM))) |=> (line_dirty && state_q == LS_MM));

    p_atomic_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_atomic) |-> $past(lcl_wr_valid && lcl_wr_atomic));

    p_mm_nomig_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_ready && rd_nomig && state_q == LS_MM) |-> (resp_kind == RK_DAT_SH));

    p_mm_nomig_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_ready && rd_nomig && state_q == LS_MM) |=> (state_q == LS_O));

    p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_ready && idle_cls) |-> (resp_kind == RK_ACK));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_ready && idle_cls) |=> $stable(state_q));

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && trans_cls) |-> (!fwd_ready && !resp_valid));

    p_getx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && fwd_is_write) |=> (!line_atomic && !line_dirty));

    p_set_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (!fwd_ready && !resp_valid));
endmodule

bind snoop_resp_top snoop_resp_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fwd_valid     (fwd_valid),
    .fwd_is_write  (fwd_is_write),
    .tag_hit       (tag_hit),
    .no_mig_en     (no_mig_en),
    .lcl_wr_valid  (lcl_wr_valid),
    .lcl_wr_atomic (lcl_wr_atomic),
    .set_valid     (set_valid),
    .fwd_ready     (fwd_ready),
    .resp_valid    (resp_valid),
    .resp_kind     (resp_kind),
    .rd_nomig      (rd_nomig),
    .state_q       (state_q),
    .line_dirty    (line_dirty),
    .line_atomic   (line_atomic)
);

// File: tb/snoop_resp_top_tb.sv
`timescale 1ns/1ps
module snoop_resp_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fwd_valid = 0, fwd_is_write = 0, tag_hit = 0, no_mig_en = 0;
    logic       lcl_wr_valid = 0, lcl_wr_atomic = 0, set_valid = 0, set_fresh = 0;
    logic [4:0] set_state = 0;
    logic       fwd_ready, resp_valid, rd_nomig, line_dirty, line_atomic;
    logic [2:0] resp_kind;
    logic [4:0] state_q;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    snoop_resp_top u_dut (.*);

    // Vector: {req4, state5, wr1, tag1, en1, atomic1, resp3, next5} = 21 bits
    localparam int NV = 29;
    localparam logic [20:0] VEC [NV] = '{
        {4'd4, 5'd4, 1'b0,1'b1,1'b1,1'b1, 3'd3, 5'd2},   // R4 MM nomig read -> O
        {4'd4, 5'd4, 1'b0,1'b1,1'b1,1'b0, 3'd4, 5'd0},   // R4 MM plain read migrates
        {4'd1, 5'd4, 1'b0,1'b1,1'b0,1'b1, 3'd4, 5'd0},   // R1 enable off
        {4'd1, 5'd4, 1'b0,1'b0,1'b1,1'b1, 3'd4, 5'd0},   // R1 tag miss
        {4'd4, 5'd4, 1'b1,1'b1,1'b1,1'b1, 3'd4, 5'd0},   // R4 write
        {4'd5, 5'd3, 1'b0,1'b1,1'b1,1'b1, 3'd3, 5'd2},   // R5
        {4'd5, 5'd3, 1'b0,1'b1,1'b1,1'b0, 3'd3, 5'd2},   // R5
        {4'd5, 5'd3, 1'b1,1'b1,1'b1,1'b0, 3'd4, 5'd0},   // R5
        {4'd6, 5'd1, 1'b0,1'b1,1'b1,1'b0, 3'd2, 5'd1},   // R6
        {4'd6, 5'd6, 1'b0,1'b1,1'b1,1'b1, 3'd2, 5'd6},   // R6
        {4'd6, 5'd2, 1'b0,1'b1,1'b1,1'b1, 3'd3, 5'd2},   // R6
        {4'd6, 5'd7, 1'b0,1'b1,1'b1,1'b0, 3'd3, 5'd7},   // R6
        {4'd7, 5'd1, 1'b1,1'b1,1'b1,1'b0, 3'd1, 5'd0},   // R7
        {4'd7, 5'd6, 1'b1,1'b1,1'b1,1'b0, 3'd1, 5'd5},   // R7
        {4'd7, 5'd2, 1'b1,1'b1,1'b1,1'b1, 3'd4, 5'd0},   // R7
        {4'd7, 5'd7, 1'b1,1'b1,1'b1,1'b0, 3'd4, 5'd5},   // R7
        {4'd8, 5'd0, 1'b0,1'b1,1'b1,1'b0, 3'd1, 5'd0},   // R8
        {4'd8, 5'd5, 1'b1,1'b1,1'b1,1'b0, 3'd1, 5'd5},   // R8
        {4'd8, 5'd8, 1'b0,1'b1,1'b1,1'b1, 3'd1, 5'd8},   // R8
        {4'd8, 5'd9, 1'b1,1'b1,1'b1,1'b0, 3'd1, 5'd9},   // R8
        {4'd10,5'd10,1'b0,1'b1,1'b1,1'b0, 3'd5, 5'd10},  // R10
        {4'd10,5'd11,1'b0,1'b1,1'b1,1'b1, 3'd5, 5'd10},  // R10
        {4'd10,5'd11,1'b1,1'b1,1'b1,1'b0, 3'd6, 5'd9},   // R10
        {4'd10,5'd10,1'b1,1'b1,1'b1,1'b0, 3'd6, 5'd9},   // R10
        {4'd9, 5'd12,1'b0,1'b1,1'b1,1'b0, 3'd0, 5'd12},  // R9
        {4'd9, 5'd13,1'b1,1'b1,1'b1,1'b0, 3'd0, 5'd13},  // R9
        {4'd9, 5'd14,1'b0,1'b1,1'b1,1'b0, 3'd0, 5'd14},  // R9
        {4'd9, 5'd15,1'b0,1'b1,1'b1,1'b1, 3'd0, 5'd15},  // R9
        {4'd9, 5'd16,1'b1,1'b1,1'b1,1'b0, 3'd0, 5'd16}   // R9
    };

    // Record one comparison.
    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Load a state through the controller port.
    task automatic load_st(input logic [4:0] s, input logic fresh);
        @(negedge clk);
        set_valid = 1; set_state = s; set_fresh = fresh;
        @(negedge clk);
        set_valid = 0; set_fresh = 0;
    endtask

    // Local write for one cycle.
    task automatic lcl_wr(input logic at);
        @(negedge clk);
        lcl_wr_valid = 1; lcl_wr_atomic = at;
        @(negedge clk);
        lcl_wr_valid = 0; lcl_wr_atomic = 0;
    endtask

    // Bring the line to state s with the atomic bit as requested.
    task automatic prime(input logic [4:0] s, input logic at);
        load_st(5'd3, 1'b1);
        if (at) lcl_wr(1'b1);
        load_st(s, 1'b0);
    endtask

    // Forwarded request: capture combinational answer, then settled state.
    task automatic fwd(input logic wr, input logic tg, input logic en,
                       output int kind, output int rdy, output int nst);
        @(negedge clk);
        fwd_valid = 1; fwd_is_write = wr; tag_hit = tg; no_mig_en = en;
        #1;
        kind = resp_kind; rdy = fwd_ready;
        @(negedge clk);
        fwd_valid = 0; fwd_is_write = 0;
        nst = state_q;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k, r, s;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(12, "reset state", state_q, 0);
        chk(12, "reset dirty", line_dirty, 0);
        chk(12, "reset atomic", line_atomic, 0);
        chk(12, "reset resp_valid", resp_valid, 0);
        rst_n = 1;

        // Table-driven response/next-state checks
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            prime(v[16:12], v[8]);
            fwd(v[11], v[10], v[9], k, r, s);
            chk(int'(v[20:17]), $sformatf("vec %0d resp", i), k, int'(v[7:5]));
            chk(int'(v[20:17]), $sformatf("vec %0d ready", i), r, (v[7:5] != 0) ? 1 : 0);
            chk(int'(v[20:17]), $sformatf("vec %0d next", i), s, int'(v[4:0]));
        end

        // R1 classification seen at the port
        prime(5'd4, 1'b1);
        @(negedge clk);
        fwd_valid = 1; fwd_is_write = 0; tag_hit = 1; no_mig_en = 1; set_valid = 0;
        #1 chk(1, "rd_nomig all conditions", rd_nomig, 1);
        fwd_is_write = 1;
        #1 chk(1, "rd_nomig on write", rd_nomig, 0);
        fwd_valid = 0; fwd_is_write = 0;

        // R2 local atomic write in M
        load_st(5'd3, 1'b1);
        lcl_wr(1'b1);
        chk(2, "atomic write state", state_q, 4);
        chk(2, "atomic write dirty", line_dirty, 1);
        chk(2, "atomic write atomic", line_atomic, 1);
        // R2 plain write
        load_st(5'd3, 1'b1);
        lcl_wr(1'b0);
        chk(2, "plain write dirty", line_dirty, 1);
        chk(2, "plain write atomic", line_atomic, 0);

        // R3 write in S ignored
        load_st(5'd1, 1'b1);
        lcl_wr(1'b1);
        chk(3, "write in S state", state_q, 1);
        chk(3, "write in S atomic", line_atomic, 0);
        chk(3, "write in S dirty", line_dirty, 0);
        // R3 write colliding with a state load
        load_st(5'd3, 1'b1);
        @(negedge clk);
        lcl_wr_valid = 1; lcl_wr_atomic = 1; set_valid = 1; set_state = 5'd3; set_fresh = 0;
        @(negedge clk);
        lcl_wr_valid = 0; lcl_wr_atomic = 0; set_valid = 0;
        chk(3, "write under load atomic", line_atomic, 0);
        chk(3, "write under load state", state_q, 3);

        // R11 clears and keeps
        prime(5'd2, 1'b1);
        chk(11, "non-fresh load keeps atomic", line_atomic, 1);
        load_st(5'd4, 1'b1);
        chk(11, "fresh load clears atomic", line_atomic, 0);
        fwd(1'b0, 1'b1, 1'b1, k, r, s);
        chk(11, "fresh line migrates resp", k, 4);
        prime(5'd2, 1'b1);
        load_st(5'd0, 1'b0);
        chk(11, "load to I clears atomic", line_atomic, 0);
        prime(5'd2, 1'b1);
        fwd(1'b1, 1'b1, 1'b1, k, r, s);
        chk(11, "write clears atomic", line_atomic, 0);
        chk(11, "write clears dirty", line_dirty, 0);

        // R13 load blocks forwarded request
        load_st(5'd3, 1'b1);
        @(negedge clk);
        set_valid = 1; set_state = 5'd6; fwd_valid = 1; fwd_is_write = 1; tag_hit = 1;
        #1;
        chk(13, "ready under load", fwd_ready, 0);
        chk(13, "resp under load", resp_valid, 0);
        @(negedge clk);
        set_valid = 0; fwd_valid = 0; fwd_is_write = 0;
        chk(13, "loaded state", state_q, 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule